// File: doc/BRIEF.md
# USB Endpoint Stall and Data-Toggle Handshake Controller

This block makes the per-endpoint handshake decisions of a USB device controller. For every endpoint it keeps a stall flag per direction, a data-toggle bit per direction and an acceptance-override flag for received data. Each endpoint is also fixed as control or non-control. A packet engine reports protocol events: a received OUT or SETUP data packet with its PID, an IN token, a PING token, or the host's ACK to an IN data packet. One clock later the block returns the handshake to send and reports whether received data was accepted or dropped. It also updates the stall and toggle state.

Software reaches the block through a one-cycle register-write port. A write addresses one endpoint and loads both stall flags and the override flag together. In the same write it can return either toggle to DATA0. Stalls set by software stay in place until software removes them. The exception is a SETUP on a control endpoint, which clears them, because a new control transfer ends a protocol stall. A data packet whose PID does not match the expected toggle is taken as a repeat of a packet already received. It is acknowledged and then dropped.

Top module: `ep_handshake_ctrl`

## Requirements
- R1: When the OUT stall flag of an endpoint is set, every OUT data packet (kind 0) and PING (kind 3) to it gets response code 3 (STALL). When the IN stall flag is set, every IN token (kind 2) gets code 3. This applies to control and non-control endpoints alike, and the flags stay set until software clears them.
- R2: A SETUP data packet (kind 1) to a non-control endpoint gets STALL while that endpoint's OUT stall flag is set. Otherwise it is handled exactly like an OUT data packet. In both cases the stall flags are left unchanged.
- R3: A SETUP data packet to a control endpoint clears both of that endpoint's stall flags, gets code 0 (ACK) and raises rxAccept, whatever its PID.
- R4: One register write loads the OUT stall flag, the IN stall flag and the override flag of the addressed endpoint in the same clock.
- R5: A register write with toggle-reset bit 1 for a direction sets that direction's toggle to DATA0 (PID value 0).
- R6: An OUT or non-control SETUP data packet whose PID (0 = DATA0, 1 = DATA1) differs from the OUT toggle, with the override flag clear, gets ACK and raises rxDiscard without rxAccept. The toggle keeps its value.
- R7: While an endpoint's override flag is 1, every received data packet that is not stalled passes the PID check, whatever its PID.
- R8: The control/non-control type of each endpoint comes only from the CTRL_MASK parameter (bit n set = endpoint n is control). Register writes leave it unchanged.
- R9: The OUT toggle flips only when a data packet is accepted. The IN toggle flips only on a host ACK event (kind 4). NAK, STALL and dropped packets leave both toggles alone.
- R10: A SETUP on a control endpoint sets both toggles of that endpoint to DATA1.
- R11: Each event is answered on the clock after it is presented, with respValid high and the code encoded as 0 ACK, 1 NAK, 2 NYET, 3 STALL, 4 no handshake. For data that passes the PID check, bufReady = 0 gives NAK. Accepted data gives NYET when highSpeed = 1 and bufNext = 0, and ACK otherwise. A PING gives ACK if bufReady is 1 and NAK if it is 0. Event kinds 5 to 7 produce no response.
- R12: An IN token with bufReady = 1 on an endpoint that is not stalled gives code 4, and txPid shows the IN toggle. A host ACK event gives code 4.
- R13: After reset all stall flags, override flags and toggles are 0, and respValid, rxAccept and rxDiscard are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evValid | input | 1 | Event present this cycle |
| evKind | input | 3 | 0 OUT data, 1 SETUP data, 2 IN token, 3 PING, 4 host ACK of IN data |
| evEp | input | EP_W | Endpoint number of the event |
| evPid | input | 1 | Data PID of a received packet, 0 DATA0, 1 DATA1 |
| bufReady | input | 1 | Endpoint buffer can take or supply a packet |
| bufNext | input | 1 | Room for a further OUT packet after this one |
| highSpeed | input | 1 | Link runs at high speed |
| cfgWrEn | input | 1 | Register write strobe |
| cfgEp | input | EP_W | Endpoint addressed by the write |
| cfgStallOut | input | 1 | New OUT stall flag |
| cfgStallIn | input | 1 | New IN stall flag |
| cfgInhibit | input | 1 | New PID-check override flag |
| cfgTogRstOut | input | 1 | Return OUT toggle to DATA0 |
| cfgTogRstIn | input | 1 | Return IN toggle to DATA0 |
| respValid | output | 1 | Handshake decision valid |
| respCode | output | 3 | Handshake code |
| rxAccept | output | 1 | Received data delivered to software |
| rxDiscard | output | 1 | Received data dropped as a repeat |
| txPid | output | 1 | Data PID for the IN packet to send |

## Verification
On every cycle the assertions check these rules: a stalled IN direction answers STALL, and a control SETUP leaves both stall flags clear and both toggles at DATA1. They also check that a non-control SETUP leaves the OUT stall flag alone, that a mismatched PID is dropped with the toggle unchanged, and that accept and discard are never raised together. Only the bench scenarios can show how the toggle evolves over a sequence of events. These cover no flip on NAK and STALL, DATA0 after a toggle-reset write, and acceptance under the override. The scenarios also cover the NYET/NAK selection, the lasting effect of a software stall until it is cleared, and the type of a control endpoint surviving register writes.

// File: rtl/ep_hs_pkg.sv
package ep_hs_pkg;

  localparam int EP_IDX_W = 4;

  typedef enum logic [2:0] {
    EV_OUT   = 3'd0,
    EV_SETUP = 3'd1,
    EV_IN    = 3'd2,
    EV_PING  = 3'd3,
    EV_INACK = 3'd4
  } ev_kind_t;

  typedef enum logic [2:0] {
    RSP_ACK   = 3'd0,
    RSP_NAK   = 3'd1,
    RSP_NYET  = 3'd2,
    RSP_STALL = 3'd3,
    RSP_NONE  = 3'd4
  } rsp_code_t;

  // strobes from the decision logic to the endpoint state store
  typedef struct packed {
    logic                hit;
    logic [EP_IDX_W-1:0] ep;
    logic                setupClr;
    logic                flipOut;
    logic                flipIn;
  } ep_upd_t;

endpackage

// File: rtl/ep_hs_state.sv
module ep_hs_state
  import ep_hs_pkg::*;
#(
  parameter int NUM_EP = 4,
  localparam int EP_W = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ep_upd_t           upd,
  input  logic              cfgWrEn,
  input  logic [EP_W-1:0]   cfgEp,
  input  logic              cfgStallOut,
  input  logic              cfgStallIn,
  input  logic              cfgInhibit,
  input  logic              cfgTogRstOut,
  input  logic              cfgTogRstIn,
  output logic [NUM_EP-1:0] stallOutV,
  output logic [NUM_EP-1:0] stallInV,
  output logic [NUM_EP-1:0] togOutV,
  output logic [NUM_EP-1:0] togInV,
  output logic [NUM_EP-1:0] inhV
);

  for (genvar i = 0; i < NUM_EP; i++) begin : gEp
    logic evHit;
    logic wrHit;
    logic nStallOut, nStallIn, nTogOut, nTogIn, nInh;

    assign evHit = upd.hit && (upd.ep == EP_IDX_W'(i));
    assign wrHit = cfgWrEn && (cfgEp == EP_W'(i));

    // event effects first, software write applied on top
    always_comb begin
      nStallOut = stallOutV[i];
      nStallIn  = stallInV[i];
      nTogOut   = togOutV[i];
      nTogIn    = togInV[i];
      nInh      = inhV[i];
      if (evHit) begin
        if (upd.setupClr) begin
          nStallOut = 1'b0;
          nStallIn  = 1'b0;
          nTogOut   = 1'b1;
          nTogIn    = 1'b1;
        end
        if (upd.flipOut) nTogOut = ~togOutV[i];
        if (upd.flipIn)  nTogIn  = ~togInV[i];
      end
      if (wrHit) begin
        nStallOut = cfgStallOut;
        nStallIn  = cfgStallIn;
        nInh      = cfgInhibit;
        if (cfgTogRstOut) nTogOut = 1'b0;
        if (cfgTogRstIn)  nTogIn  = 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stallOutV[i] <= 1'b0;
        stallInV[i]  <= 1'b0;
        togOutV[i]   <= 1'b0;
        togInV[i]    <= 1'b0;
        inhV[i]      <= 1'b0;
      end else begin
        stallOutV[i] <= nStallOut;
        stallInV[i]  <= nStallIn;
        togOutV[i]   <= nTogOut;
        togInV[i]    <= nTogIn;
        inhV[i]      <= nInh;
      end
    end
  end

endmodule

// File: rtl/ep_hs_decide.sv
module ep_hs_decide
  import ep_hs_pkg::*;
#(
  parameter int              NUM_EP    = 4,
  parameter logic [NUM_EP-1:0] CTRL_MASK = 1,
  localparam int EP_W = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evValid,
  input  logic [2:0]        evKind,
  input  logic [EP_W-1:0]   evEp,
  input  logic              evPid,
  input  logic              bufReady,
  input  logic              bufNext,
  input  logic              highSpeed,
  input  logic [NUM_EP-1:0] stallOutV,
  input  logic [NUM_EP-1:0] stallInV,
  input  logic [NUM_EP-1:0] togOutV,
  input  logic [NUM_EP-1:0] togInV,
  input  logic [NUM_EP-1:0] inhV,
  output ep_upd_t           upd,
  output logic              respValid,
  output logic [2:0]        respCode,
  output logic              rxAccept,
  output logic              rxDiscard,
  output logic              txPid
);

  logic      epOk;
  logic      isCtrl, sOut, sIn, tOut, tIn, inh;
  logic      nValid, nAcc, nDis, nTx;
  rsp_code_t nCode;

  assign epOk   = (int'(evEp) < NUM_EP);
  assign isCtrl = epOk && CTRL_MASK[evEp];
  assign sOut   = epOk && stallOutV[evEp];
  assign sIn    = epOk && stallInV[evEp];
  assign tOut   = epOk && togOutV[evEp];
  assign tIn    = epOk && togInV[evEp];
  assign inh    = epOk && inhV[evEp];

  // received data past the stall check: PID check, then buffer state
  task automatic dataRx(output rsp_code_t code, output logic acc,
                        output logic dis, output logic flip);
    acc  = 1'b0;
    dis  = 1'b0;
    flip = 1'b0;
    if (!inh && (evPid != tOut)) begin
      code = RSP_ACK;
      dis  = 1'b1;
    end else if (!bufReady) begin
      code = RSP_NAK;
    end else begin
      acc  = 1'b1;
      flip = 1'b1;
      code = (highSpeed && !bufNext) ? RSP_NYET : RSP_ACK;
    end
  endtask

  always_comb begin
    logic fo;
    nValid = 1'b0;
    nCode  = RSP_NONE;
    nAcc   = 1'b0;
    nDis   = 1'b0;
    nTx    = txPid;
    fo     = 1'b0;
    upd    = '0;
    upd.ep = EP_IDX_W'(evEp);
    if (evValid && epOk) begin
      nValid = 1'b1;
      unique case (evKind)
        EV_SETUP: begin
          if (isCtrl) begin
            nCode        = RSP_ACK;
            nAcc         = 1'b1;
            upd.setupClr = 1'b1;
          end else if (sOut) begin
            nCode = RSP_STALL;
          end else begin
            dataRx(nCode, nAcc, nDis, fo);
          end
        end
        EV_OUT: begin
          if (sOut) nCode = RSP_STALL;
          else      dataRx(nCode, nAcc, nDis, fo);
        end
        EV_PING: begin
          if (sOut)          nCode = RSP_STALL;
          else if (bufReady) nCode = RSP_ACK;
          else               nCode = RSP_NAK;
        end
        EV_IN: begin
          if (sIn) begin
            nCode = RSP_STALL;
          end else if (bufReady) begin
            nCode = RSP_NONE;
            nTx   = tIn;
          end else begin
            nCode = RSP_NAK;
          end
        end
        EV_INACK: begin
          nCode      = RSP_NONE;
          upd.flipIn = 1'b1;
        end
        default: nValid = 1'b0;
      endcase
      upd.flipOut = fo;
      upd.hit     = nValid;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      respValid <= 1'b0;
      respCode  <= RSP_NONE;
      rxAccept  <= 1'b0;
      rxDiscard <= 1'b0;
      txPid     <= 1'b0;
    end else begin
      respValid <= nValid;
      respCode  <= nCode;
      rxAccept  <= nAcc;
      rxDiscard <= nDis;
      txPid     <= nTx;
    end
  end

endmodule

// File: rtl/ep_handshake_ctrl.sv
module ep_handshake_ctrl
  import ep_hs_pkg::*;
#(
  parameter int                NUM_EP    = 4,
  parameter logic [NUM_EP-1:0] CTRL_MASK = 1,
  localparam int EP_W = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            evValid,
  input  logic [2:0]      evKind,
  input  logic [EP_W-1:0] evEp,
  input  logic            evPid,
  input  logic            bufReady,
  input  logic            bufNext,
  input  logic            highSpeed,
  input  logic            cfgWrEn,
  input  logic [EP_W-1:0] cfgEp,
  input  logic            cfgStallOut,
  input  logic            cfgStallIn,
  input  logic            cfgInhibit,
  input  logic            cfgTogRstOut,
  input  logic            cfgTogRstIn,
  output logic            respValid,
  output logic [2:0]      respCode,
  output logic            rxAccept,
  output logic            rxDiscard,
  output logic            txPid
);

  ep_upd_t           upd;
  logic [NUM_EP-1:0] stallOutV, stallInV, togOutV, togInV, inhV;

  ep_hs_decide #(.NUM_EP(NUM_EP), .CTRL_MASK(CTRL_MASK)) uDecide (
    .clk(clk), .rst_n(rst_n),
    .evValid(evValid), .evKind(evKind), .evEp(evEp), .evPid(evPid),
    .bufReady(bufReady), .bufNext(bufNext), .highSpeed(highSpeed),
    .stallOutV(stallOutV), .stallInV(stallInV), .togOutV(togOutV),
    .togInV(togInV), .inhV(inhV), .upd(upd),
    .respValid(respValid), .respCode(respCode), .rxAccept(rxAccept),
    .rxDiscard(rxDiscard), .txPid(txPid)
  );

  ep_hs_state #(.NUM_EP(NUM_EP)) uState (
    .clk(clk), .rst_n(rst_n), .upd(upd),
    .cfgWrEn(cfgWrEn), .cfgEp(cfgEp), .cfgStallOut(cfgStallOut),
    .cfgStallIn(cfgStallIn), .cfgInhibit(cfgInhibit),
    .cfgTogRstOut(cfgTogRstOut), .cfgTogRstIn(cfgTogRstIn),
    .stallOutV(stallOutV), .stallInV(stallInV), .togOutV(togOutV),
    .togInV(togInV), .inhV(inhV)
  );

endmodule

// File: rtl/ep_hs_checker.sv
module ep_hs_checker #(
  parameter int                NUM_EP    = 4,
  parameter logic [NUM_EP-1:0] CTRL_MASK = 1,
  localparam int EP_W = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              evValid,
  input logic [2:0]        evKind,
  input logic [EP_W-1:0]   evEp,
  input logic              evPid,
  input logic              cfgWrEn,
  input logic              respValid,
  input logic [2:0]        respCode,
  input logic              rxAccept,
  input logic              rxDiscard,
  input logic [NUM_EP-1:0] stallOutV,
  input logic [NUM_EP-1:0] stallInV,
  input logic [NUM_EP-1:0] togOutV,
  input logic [NUM_EP-1:0] togInV,
  input logic [NUM_EP-1:0] inhV
);

  AST_IN_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    evValid && evKind == 3'd2 && stallInV[evEp] && !cfgWrEn
    |=> respValid && respCode == 3'd3); // R1

  AST_NONCTRL_SETUP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    evValid && evKind == 3'd1 && !CTRL_MASK[evEp] && !cfgWrEn
    |=> stallOutV[$past(evEp)] == $past(stallOutV[evEp])); // R2

  AST_CTRL_SETUP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    evValid && evKind == 3'd1 && CTRL_MASK[evEp] && !cfgWrEn
    |=> respCode == 3'd0 && rxAccept && !stallOutV[$past(evEp)]
        && !stallInV[$past(evEp)]); // R3

  AST_CTRL_SETUP_DATA1: assert property (@(posedge clk) disable iff (!rst_n)
    evValid && evKind == 3'd1 && CTRL_MASK[evEp] && !cfgWrEn
    |=> togOutV[$past(evEp)] && togInV[$past(evEp)]); // R10

  AST_MISMATCH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    evValid && evKind == 3'd0 && !stallOutV[evEp] && !inhV[evEp]
    && evPid != togOutV[evEp] && !cfgWrEn
    |=> rxDiscard && !rxAccept && respCode == 3'd0
        && togOutV[$past(evEp)] == $past(togOutV[evEp])); // R6

  AST_ACC_DIS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rxAccept, rxDiscard})); // R6

  AST_RESP_FOLLOWS_EV: assert property (@(posedge clk) disable iff (!rst_n)
    respValid |-> $past(evValid)); // R11

endmodule

bind ep_handshake_ctrl ep_hs_checker #(.NUM_EP(NUM_EP), .CTRL_MASK(CTRL_MASK)) uChk (.*);

// File: tb/ep_handshake_ctrl_test.sv
module ep_handshake_ctrl_test;

  localparam int NUM_EP = 4;
  localparam int EP_W   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic evValid = 0, evPid = 0, bufReady = 0, bufNext = 0, highSpeed = 0;
  logic [2:0] evKind = 0;
  logic [EP_W-1:0] evEp = 0, cfgEp = 0;
  logic cfgWrEn = 0, cfgStallOut = 0, cfgStallIn = 0, cfgInhibit = 0;
  logic cfgTogRstOut = 0, cfgTogRstIn = 0;
  logic respValid, rxAccept, rxDiscard, txPid;
  logic [2:0] respCode;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [2:0] code;
    bit acc;
    bit dis;
    bit chkTx;
    bit tx;
    string tag;
  } exp_t;
  exp_t expQ[$];

  always #2.5 clk = ~clk;

  ep_handshake_ctrl #(.NUM_EP(NUM_EP), .CTRL_MASK(4'b0001)) uut (.*);

  // monitor: pop one expectation per response
  always @(negedge clk) begin
    if (rst_n && respValid) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R11 response without event: code=%0d expected none", respCode);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        if (respCode !== e.code || rxAccept !== e.acc || rxDiscard !== e.dis
            || (e.chkTx && txPid !== e.tx)) begin
          errors++;
          $display("FAIL %s code/acc/dis/tx=%0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d",
                   e.tag, respCode, rxAccept, rxDiscard, txPid, e.code, e.acc, e.dis, e.tx);
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // driver: present one event and queue its expected response
  task automatic ev(input logic [2:0] k, input int ep, input bit pid, input bit rdy,
                    input bit nxt, input bit hs, input logic [2:0] code, input bit acc,
                    input bit dis, input bit chkTx, input bit tx, input string tag);
    exp_t e;
    @(negedge clk);
    evValid = 1; evKind = k; evEp = EP_W'(ep); evPid = pid;
    bufReady = rdy; bufNext = nxt; highSpeed = hs;
    if (k <= 3'd4) begin
      e.code = code; e.acc = acc; e.dis = dis; e.chkTx = chkTx; e.tx = tx; e.tag = tag;
      expQ.push_back(e);
    end
    @(negedge clk);
    evValid = 0;
  endtask

  task automatic wr(input int ep, input bit so, input bit si, input bit inh,
                    input bit tro, input bit tri_);
    @(negedge clk);
    cfgWrEn = 1; cfgEp = EP_W'(ep); cfgStallOut = so; cfgStallIn = si;
    cfgInhibit = inh; cfgTogRstOut = tro; cfgTogRstIn = tri_;
    @(negedge clk);
    cfgWrEn = 0; cfgTogRstOut = 0; cfgTogRstIn = 0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(respValid == 0 && rxAccept == 0 && rxDiscard == 0, "R13 outputs idle", respValid, 0);

    // IN toggle sequence on ep1
    ev(2, 1, 0, 1, 0, 0, 3'd4, 0, 0, 1, 0, "R12 R13 IN ready DATA0");
    ev(4, 1, 0, 0, 0, 0, 3'd4, 0, 0, 0, 0, "R12 host ack");
    ev(2, 1, 0, 1, 0, 0, 3'd4, 0, 0, 1, 1, "R9 IN toggled to DATA1");
    ev(2, 1, 0, 0, 0, 0, 3'd1, 0, 0, 0, 0, "R11 IN NAK");
    ev(2, 1, 0, 1, 0, 0, 3'd4, 0, 0, 1, 1, "R9 no flip on NAK");

    // OUT data sequence on ep1
    ev(0, 1, 0, 1, 1, 0, 3'd0, 1, 0, 0, 0, "R11 OUT accept ACK");
    ev(0, 1, 0, 1, 1, 0, 3'd0, 0, 1, 0, 0, "R6 repeat DATA0 dropped");
    ev(0, 1, 1, 0, 0, 0, 3'd1, 0, 0, 0, 0, "R11 OUT NAK");
    ev(0, 1, 1, 1, 0, 1, 3'd2, 1, 0, 0, 0, "R11 R9 OUT NYET accept");
    ev(0, 1, 0, 1, 1, 1, 3'd0, 1, 0, 0, 0, "R9 toggle back to DATA0");

    // software stall on ep1
    wr(1, 1, 1, 0, 0, 0);
    ev(0, 1, 1, 1, 1, 0, 3'd3, 0, 0, 0, 0, "R1 R4 OUT stalled");
    ev(2, 1, 0, 1, 0, 0, 3'd3, 0, 0, 0, 0, "R1 R4 IN stalled");
    ev(3, 1, 0, 1, 0, 0, 3'd3, 0, 0, 0, 0, "R1 PING stalled");
    ev(1, 1, 1, 1, 1, 0, 3'd3, 0, 0, 0, 0, "R2 noncontrol SETUP stalled");
    ev(0, 1, 1, 1, 1, 0, 3'd3, 0, 0, 0, 0, "R1 R2 stall persists");
    wr(1, 0, 0, 0, 0, 0);
    ev(3, 1, 0, 1, 0, 0, 3'd0, 0, 0, 0, 0, "R1 PING ACK after clear");
    ev(3, 1, 0, 0, 0, 0, 3'd1, 0, 0, 0, 0, "R11 PING NAK");
    ev(1, 1, 1, 1, 1, 0, 3'd0, 1, 0, 0, 0, "R2 noncontrol SETUP normal");

    // toggle reset on ep1
    wr(1, 0, 0, 0, 1, 1);
    ev(2, 1, 0, 1, 0, 0, 3'd4, 0, 0, 1, 0, "R5 IN back to DATA0");
    ev(0, 1, 0, 1, 1, 0, 3'd0, 1, 0, 0, 0, "R5 OUT expects DATA0");

    // override on ep2
    wr(2, 0, 0, 1, 0, 0);
    ev(0, 2, 1, 1, 1, 0, 3'd0, 1, 0, 0, 0, "R7 DATA1 accepted");
    ev(0, 2, 1, 1, 1, 0, 3'd0, 1, 0, 0, 0, "R7 DATA1 again accepted");

    // control endpoint 0
    wr(0, 1, 1, 0, 0, 0);
    ev(2, 0, 0, 1, 0, 0, 3'd3, 0, 0, 0, 0, "R1 control IN stalled");
    ev(1, 0, 0, 1, 1, 0, 3'd0, 1, 0, 0, 0, "R3 R8 control SETUP clears");
    ev(2, 0, 0, 1, 0, 0, 3'd4, 0, 0, 1, 1, "R10 R3 IN data stage DATA1");
    ev(0, 0, 1, 1, 1, 0, 3'd0, 1, 0, 0, 0, "R10 OUT expects DATA1");
    ev(1, 0, 1, 1, 1, 0, 3'd0, 1, 0, 0, 0, "R3 SETUP any PID accepted");

    // reserved kind: no response
    ev(5, 1, 0, 1, 1, 0, 3'd0, 0, 0, 0, 0, "R11 reserved");
    check(respValid == 0, "R11 no response to kind 5", respValid, 0);

    repeat (3) @(negedge clk);
    while (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      check(0, {e.tag, " missing response"}, 0, 1);
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule